// File: doc/BRIEF.md
# Masked-Write GPIO Port

This block is a 32-pin general-purpose I/O port behind a small 32-bit register interface. Software turns pins into outputs or inputs with two strobe registers. A one in a written word sets or clears the direction bit of that pin, and a zero leaves it alone. Because of this, several agents can change disjoint pins without a read-modify-write.

Output levels sit in two half-word latches: one for the low sixteen pins and one for the high sixteen. Each write to a latch carries a per-bit enable mask in its upper half, so a single pin can be driven high or low without disturbing its neighbours. A latch keeps its value whatever the pin's direction is, so a value can be loaded before the pin is turned into an output. The pin levels reach software through a two-flop synchronizer and can be read at one offset. Pad cells, pulls and interrupts sit outside this block.

The bus is a plain valid/write/address/data port. Writes take effect at the clock edge on which they are presented. Read data is combinational in the same cycle and is zero whenever no read is presented.

Top module: `gpio_mask_port`

## Requirements
- R1: After reset, `pin_oe` is all zeros (every pin an input) and `pin_out` is all zeros.
- R2: A write to offset 0x00 sets to 1 every `pin_oe` bit whose data bit is 1. Bits written as 0 keep their value.
- R3: A write to offset 0x04 clears to 0 every `pin_oe` bit whose data bit is 1. Bits written as 0 keep their value.
- R4: A write to offset 0x08 updates `pin_out[15:0]`. Data bits 31:16 are a mask and bits 15:0 are the new levels. Only pins whose mask bit is 1 change, and `pin_out[31:16]` is untouched.
- R5: A write to offset 0x0C updates `pin_out[31:16]` in the same way. Mask bit k (data bit 16+k) selects pin 16+k, and level bit k (data bit k) gives its new value. `pin_out[15:0]` is untouched.
- R6: The output latches hold their value while a pin is an input and across any change of direction. A value loaded while a pin is an input appears unchanged on `pin_out` once the pin is made an output.
- R7: A read of offset 0x10 returns `pin_in` through a two-stage synchronizer. A level change applied between two clock edges shows up after the second following edge, and not after the first.
- R8: Reads of 0x00 and 0x04 return the direction vector. Reads of 0x08 and 0x0C return the low or high latch in bits 15:0, with bits 31:16 reading as zero.
- R9: A write to any other offset changes neither `pin_oe` nor `pin_out`. A read of any other offset returns zero, and `bus_rdata` is zero when `bus_valid` is low.
- R10: A write changes `pin_oe` or `pin_out` at the first rising clock edge while it is presented, and not before that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_valid | input | 1 | Register access presented this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, same cycle |
| pin_in | input | 32 | Asynchronous pin levels |
| pin_out | output | 32 | Output latch levels toward the pads |
| pin_oe | output | 32 | Per-pin output enable, 1 = output |

## Verification
A corrupted direction bit or latch bit appears directly on `pin_oe` or `pin_out` at the edge after the faulty write, so every bus write is followed by a comparison of both vectors against a model of the set/clear and masked-merge rules. A mask applied to the wrong half, or a clear strobe that also touches bits written as zero, shows as a neighbouring pin that moves when it should stay. A synchronizer that is one stage too short or too long is caught by reading the input register after exactly one edge and again after two.

// File: rtl/gpio_mask_pkg.sv
package gpio_mask_pkg;

    localparam int unsigned OFS_DIR_SET = 32'h00;
    localparam int unsigned OFS_DIR_CLR = 32'h04;
    localparam int unsigned OFS_LAT_LO  = 32'h08;
    localparam int unsigned OFS_LAT_HI  = 32'h0C;
    localparam int unsigned OFS_PIN_RD  = 32'h10;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_DIR_SET,
        SEL_DIR_CLR,
        SEL_LAT_LO,
        SEL_LAT_HI,
        SEL_PIN_RD
    } gpio_sel_e;

    function automatic gpio_sel_e gpio_decode(input logic [31:0] ofs);
        case (ofs)
            OFS_DIR_SET: return SEL_DIR_SET;
            OFS_DIR_CLR: return SEL_DIR_CLR;
            OFS_LAT_LO:  return SEL_LAT_LO;
            OFS_LAT_HI:  return SEL_LAT_HI;
            OFS_PIN_RD:  return SEL_PIN_RD;
            default:     return SEL_NONE;
        endcase
    endfunction

endpackage

// File: rtl/gpio_sync_chain.sv
module gpio_sync_chain #(
    parameter int unsigned WIDTH  = 32,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);

    logic [WIDTH-1:0] stage_d [STAGES];
    logic [WIDTH-1:0] stage_q [STAGES];

    always_comb begin
        stage_d[0] = async_in;
        for (int i = 1; i < int'(STAGES); i++) begin
            stage_d[i] = stage_q[i-1];
        end
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < int'(STAGES); i++) begin
            if (!rst_n) stage_q[i] <= '0;
            else        stage_q[i] <= stage_d[i];
        end
    end

    assign sync_out = stage_q[STAGES-1];

endmodule

// File: rtl/gpio_half_latch.sv
module gpio_half_latch #(
    parameter int unsigned HALF_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [HALF_W-1:0] wr_mask,
    input  logic [HALF_W-1:0] wr_val,
    output logic [HALF_W-1:0] lat_out
);

    logic [HALF_W-1:0] lat_d;
    logic [HALF_W-1:0] lat_q;

    always_comb begin
        lat_d = lat_q;
        if (wr_en) begin
            lat_d = (lat_q & ~wr_mask) | (wr_val & wr_mask);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) lat_q <= '0;
        else        lat_q <= lat_d;
    end

    assign lat_out = lat_q;

endmodule

// File: rtl/gpio_mask_port.sv
module gpio_mask_port
    import gpio_mask_pkg::*;
#(
    parameter int unsigned DATA_W      = 32,
    parameter int unsigned ADDR_W      = 8,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [DATA_W-1:0] pin_in,
    output logic [DATA_W-1:0] pin_out,
    output logic [DATA_W-1:0] pin_oe
);

    localparam int unsigned HALF_W  = DATA_W / 2;
    localparam int unsigned N_HALVES = 2;

    typedef struct packed {
        logic [DATA_W-1:0] oe;
    } dir_state_t;

    dir_state_t        dir_d;
    dir_state_t        dir_q;
    gpio_sel_e         sel;
    logic              wr_hit;
    logic              rd_hit;
    logic [DATA_W-1:0] pin_sync;
    logic [HALF_W-1:0] lat_q [N_HALVES];

    assign sel    = gpio_decode(32'(bus_addr));
    assign wr_hit = bus_valid &&  bus_write;
    assign rd_hit = bus_valid && !bus_write;

    // Direction vector: set/clear strobes
    always_comb begin
        dir_d = dir_q;
        if (wr_hit && sel == SEL_DIR_SET) dir_d.oe = dir_q.oe |  bus_wdata;
        if (wr_hit && sel == SEL_DIR_CLR) dir_d.oe = dir_q.oe & ~bus_wdata;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) dir_q <= '0;
        else        dir_q <= dir_d;
    end

    // Output latches, one per half of the port
    for (genvar h = 0; h < int'(N_HALVES); h++) begin : g_half
        localparam gpio_sel_e MY_SEL = (h == 0) ? SEL_LAT_LO : SEL_LAT_HI;
        gpio_half_latch #(.HALF_W(HALF_W)) u_lat (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_en   (wr_hit && sel == MY_SEL),
            .wr_mask (bus_wdata[DATA_W-1:HALF_W]),
            .wr_val  (bus_wdata[HALF_W-1:0]),
            .lat_out (lat_q[h])
        );
    end

    gpio_sync_chain #(.WIDTH(DATA_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (pin_in),
        .sync_out (pin_sync)
    );

    // Same-cycle read mux
    always_comb begin
        bus_rdata = '0;
        if (rd_hit) begin
            case (sel)
                SEL_DIR_SET, SEL_DIR_CLR: bus_rdata = dir_q.oe;
                SEL_LAT_LO: bus_rdata = {{HALF_W{1'b0}}, lat_q[0]};
                SEL_LAT_HI: bus_rdata = {{HALF_W{1'b0}}, lat_q[1]};
                SEL_PIN_RD: bus_rdata = pin_sync;
                default:    bus_rdata = '0;
            endcase
        end
    end

    assign pin_oe  = dir_q.oe;
    assign pin_out = {lat_q[1], lat_q[0]};

endmodule

// File: rtl/gpio_mask_port_chk.sv
module gpio_mask_port_chk
    import gpio_mask_pkg::*;
#(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned ADDR_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_valid,
    input logic              bus_write,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic [DATA_W-1:0] bus_rdata,
    input logic [DATA_W-1:0] pin_out,
    input logic [DATA_W-1:0] pin_oe
);

    localparam int unsigned HALF_W = DATA_W / 2;

    logic wr_set, wr_clr, wr_lo, wr_hi, rd_bad;

    assign wr_set = bus_valid && bus_write && 32'(bus_addr) == OFS_DIR_SET;
    assign wr_clr = bus_valid && bus_write && 32'(bus_addr) == OFS_DIR_CLR;
    assign wr_lo  = bus_valid && bus_write && 32'(bus_addr) == OFS_LAT_LO;
    assign wr_hi  = bus_valid && bus_write && 32'(bus_addr) == OFS_LAT_HI;
    assign rd_bad = bus_valid && !bus_write && gpio_decode(32'(bus_addr)) == SEL_NONE;

    // R2
    dir_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_set |=> ((pin_oe & $past(bus_wdata)) == $past(bus_wdata)));

    // R3
    dir_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_clr |=> ((pin_oe & $past(bus_wdata)) == '0));

    // R9
    dir_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_set || wr_clr) |=> $stable(pin_oe));

    // R4
    lat_lo_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_lo |=> (((pin_out[HALF_W-1:0] ^ $past(bus_wdata[HALF_W-1:0]))
                   & $past(bus_wdata[DATA_W-1:HALF_W])) == '0));

    // R5
    lat_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_hi |=> (((pin_out[DATA_W-1:HALF_W] ^ $past(bus_wdata[HALF_W-1:0]))
                   & $past(bus_wdata[DATA_W-1:HALF_W])) == '0));

    // R6
    lat_lo_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_lo |=> $stable(pin_out[HALF_W-1:0]));

    // R6
    lat_hi_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_hi |=> $stable(pin_out[DATA_W-1:HALF_W]));

    // R9
    rd_unmapped_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_bad || !bus_valid) |-> (bus_rdata == '0));

endmodule

bind gpio_mask_port gpio_mask_port_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_valid (bus_valid),
    .bus_write (bus_write),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .pin_out   (pin_out),
    .pin_oe    (pin_oe)
);

// File: tb/gpio_mask_port_bench.sv
`timescale 1ns/1ps
module gpio_mask_port_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_valid = 1'b0;
    logic        bus_write = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [31:0] pin_in = '0;
    logic [31:0] pin_out;
    logic [31:0] pin_oe;

    int checks = 0;
    int errors = 0;
    logic [31:0] rd;

    always #10 clk = ~clk;

    gpio_mask_port u_gpio_mask_port (
        .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_valid = 1'b0; bus_write = 1'b0;
    endtask

    task automatic rdreg(input logic [7:0] a, output logic [31:0] d);
        bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        bus_valid = 1'b0;
    endtask

    task automatic t_reset;
        chk("R1 pin_oe after reset", pin_oe, 32'h0);
        chk("R1 pin_out after reset", pin_out, 32'h0);
        rdreg(8'h04, rd); chk("R1 dir read", rd, 32'h0);
    endtask

    task automatic t_dir_set;
        wr(8'h00, 32'h0000_00F5);
        chk("R2 set first", pin_oe, 32'h0000_00F5);
        wr(8'h00, 32'h0F00_0000);
        chk("R2 set keeps others", pin_oe, 32'h0F00_00F5);
    endtask

    task automatic t_dir_clr;
        wr(8'h04, 32'h0000_0005);
        chk("R3 clear", pin_oe, 32'h0F00_00F0);
        rdreg(8'h04, rd); chk("R8 read 0x04", rd, 32'h0F00_00F0);
        rdreg(8'h00, rd); chk("R8 read 0x00", rd, 32'h0F00_00F0);
    endtask

    task automatic t_lat_lo;
        wr(8'h08, 32'h00FF_1234);
        chk("R4 low mask 00FF", pin_out, 32'h0000_0034);
        wr(8'h08, 32'hFF00_ABCD);
        chk("R4 low mask FF00", pin_out, 32'h0000_AB34);
        wr(8'h08, 32'h0000_FFFF);
        chk("R4 zero mask no change", pin_out, 32'h0000_AB34);
        rdreg(8'h08, rd); chk("R8 read 0x08", rd, 32'h0000_AB34);
    endtask

    task automatic t_lat_hi;
        wr(8'h0C, 32'hFFFF_5A5A);
        chk("R5 high write", pin_out, 32'h5A5A_AB34);
        wr(8'h0C, 32'h0003_0001);
        chk("R5 high partial", pin_out, 32'h5A59_AB34);
        rdreg(8'h0C, rd); chk("R8 read 0x0C", rd, 32'h0000_5A59);
    endtask

    task automatic t_hold;
        wr(8'h04, 32'hFFFF_FFFF);
        chk("R3 clear all", pin_oe, 32'h0);
        chk("R6 latch kept over clear", pin_out, 32'h5A59_AB34);
        wr(8'h08, 32'h0001_0001);
        chk("R6 write while input", pin_out, 32'h5A59_AB35);
        wr(8'h00, 32'h0000_0001);
        chk("R6 oe bit0", pin_oe, 32'h0000_0001);
        chk("R6 value after enable", pin_out, 32'h5A59_AB35);
    endtask

    task automatic t_sync;
        @(negedge clk);
        pin_in = 32'hA5A5_0F0F;
        @(negedge clk);
        rdreg(8'h10, rd); chk("R7 after one edge", rd, 32'h0);
        @(negedge clk);
        rdreg(8'h10, rd); chk("R7 after two edges", rd, 32'hA5A5_0F0F);
        pin_in = 32'h1234_8001;
        @(negedge clk);
        rdreg(8'h10, rd); chk("R7 second one edge", rd, 32'hA5A5_0F0F);
        @(negedge clk);
        rdreg(8'h10, rd); chk("R7 second two edges", rd, 32'h1234_8001);
    endtask

    task automatic t_unmapped;
        wr(8'h14, 32'hFFFF_FFFF);
        chk("R9 oe after unmapped write", pin_oe, 32'h0000_0001);
        chk("R9 out after unmapped write", pin_out, 32'h5A59_AB35);
        wr(8'h02, 32'hFFFF_FFFF);
        chk("R9 oe after unaligned write", pin_oe, 32'h0000_0001);
        chk("R9 out after unaligned write", pin_out, 32'h5A59_AB35);
        rdreg(8'h14, rd); chk("R9 read 0x14", rd, 32'h0);
        rdreg(8'h02, rd); chk("R9 read 0x02", rd, 32'h0);
        bus_addr = 8'h04; #1 chk("R9 no valid", bus_rdata, 32'h0);
    endtask

    task automatic t_timing;
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b1; bus_addr = 8'h00; bus_wdata = 32'h8000_0000;
        #1 chk("R10 before edge", pin_oe, 32'h0000_0001);
        @(posedge clk); #1;
        chk("R10 after edge", pin_oe, 32'h8000_0001);
        @(negedge clk);
        bus_valid = 1'b0; bus_write = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset;
        rst_n = 1'b1;
        @(negedge clk);
        t_reset;
        t_dir_set;
        t_dir_clr;
        t_lat_lo;
        t_lat_hi;
        t_hold;
        t_sync;
        t_unmapped;
        t_timing;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule